// File: doc/BRIEF.md
# SMBus Host Command Sequencer

This block is the transaction layer of an SMBus host controller. Software programs a small byte-addressed register file with a target address, a command code, up to 32 payload bytes and, for block writes, a byte count. It then writes a protocol code into the protocol register. That write starts the transaction. The sequencer turns the protocol code into an ordered list of bus actions: start, address byte, command byte, count and payload bytes, repeated start, reads with or without acknowledge, and stop. It hands these actions one at a time to a byte-level bus engine over a request/acknowledge handshake.

Bytes that come back from the bus are stored in the data registers, and a received block length goes into the byte-count register. At the end the sequencer writes a completion status with a done flag and a 5-bit result code, and returns the protocol register to zero, which software polls as the end-of-transaction signal. An alarm input from the bus side latches an alarm address and two alarm data bytes and raises an alarm flag in the status register.

Top module: `smb_host_seq`

## Requirements
- R1: After reset every register reads 0x00 and `eng_req` is low.
- R2: A nonzero write to the protocol register (offset 0x00) while it reads 0 starts a transaction. While the transaction runs, the register reads back the code, and further writes to it are ignored.
- R3: At completion the protocol register reads 0x00. The status register (offset 0x01) then holds done in bit 7 and the result in bits 4:0, where 0x00 means success.
- R4: Engine command encoding is start=0, write=1, read-with-ACK=2, read-with-NACK=3, stop=4. The address byte is address-register bits 7:1 followed by the direction bit (1 = read). Quick write (0x02) and quick read (0x03) issue start, address, stop. Send byte (0x04) adds the command byte. Receive byte (0x05) issues start, read address, one NACK read into data register 0 (offset 0x04), stop.
- R5: Byte-data and word-data writes (0x06, 0x08) send the command byte and then 1 or 2 data bytes, low byte from data 0 and high byte from data 1. Their reads (0x07, 0x09) send the command byte and then a repeated start with the read address. They read 1 or 2 bytes, the last with NACK, storing the low byte first.
- R6: Process call (0x0C) writes the two data bytes, issues a repeated start and reads two bytes back into data 0 and data 1.
- R7: Block write (0x0A) sends the command, then the byte count (offset 0x24), then that many data bytes. A count of 0 or above 32 ends at once with result 0x19 and no bus activity.
- R8: Block read (0x0B) reads the count byte with ACK and stores it at offset 0x24. It then reads that many bytes into data 0 upward, the last with NACK. A received count of 0 or above 32 ends with stop and result 0x11.
- R9: Block process call (0x0D) performs the block write part, a repeated start, and then the block read part.
- R10: A NACK of an address byte ends the transaction with stop and result 0x10. A NACK of any later written byte ends it with stop and result 0x11.
- R11: A code with bit 7 set, or any code outside the listed ones, ends at once with result 0x19 and no bus activity.
- R12: Any write to the status register clears done (bit 7) and alarm (bit 6).
- R13: An `alarm_evt` pulse loads offset 0x25 with the alarm address, offset 0x26 with the low data byte and offset 0x27 with the high data byte, and sets status bit 6.
- R14: `eng_cmd` and `eng_wdata` stay stable while `eng_req` is high until `eng_ack`, and each `eng_ack` completes exactly one command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 6 | Register offset |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data at `host_addr` |
| alarm_evt | input | 1 | Alarm received from the bus side |
| alarm_addr_in | input | 8 | Address carried by the alarm |
| alarm_data_in | input | 16 | Data carried by the alarm |
| eng_req | output | 1 | Command request to the byte engine |
| eng_cmd | output | 3 | Engine command code |
| eng_wdata | output | 8 | Byte to transmit for a write command |
| eng_ack | input | 1 | Engine completed the current command (one-cycle pulse) |
| eng_rdata | input | 8 | Byte received by a read command, valid with `eng_ack` |
| eng_got_ack | input | 1 | Target acknowledged the written byte, valid with `eng_ack` |

## Verification
The assertions assume a byte engine that pulses `eng_ack` for one cycle only while `eng_req` is high, and waits at least one cycle before taking the next command. They also assume the host leaves the address, command and data registers alone while the protocol register is nonzero, because the transmitted bytes are read live from those registers. The bench engine model accepts a request, answers it one cycle later and then idles a cycle. Every scenario task polls the protocol register back to zero before it programs the next transaction. The single busy-time write in the stimulus targets only the protocol register, which R2 requires to be ignored.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;

  typedef enum logic [2:0] {
    ENG_START   = 3'd0,
    ENG_WRITE   = 3'd1,
    ENG_RD_ACK  = 3'd2,
    ENG_RD_NACK = 3'd3,
    ENG_STOP    = 3'd4
  } eng_cmd_e;

  typedef enum logic [1:0] {
    XF_NONE  = 2'd0,
    XF_ONE   = 2'd1,
    XF_TWO   = 2'd2,
    XF_BLOCK = 2'd3
  } xfer_e;

  typedef enum logic [3:0] {
    S_IDLE, S_START1, S_ADDR1, S_CMD, S_WCNT, S_WDATA,
    S_START2, S_ADDR2, S_RCNT, S_RDATA, S_STOP, S_FIN
  } seq_st_e;

  // Shape of one protocol: which phases it runs and how many bytes each moves.
  typedef struct packed {
    logic  valid;
    logic  addr1_rd;
    logic  send_cmd;
    xfer_e wr;
    logic  rstart;
    xfer_e rd;
  } plan_t;

  localparam logic [4:0] RES_OK       = 5'h00;
  localparam logic [4:0] RES_ADDR_NAK = 5'h10;
  localparam logic [4:0] RES_DEV_ERR  = 5'h11;
  localparam logic [4:0] RES_UNSUP    = 5'h19;

  function automatic plan_t decode_proto(input logic [7:0] code);
    plan_t p;
    p = '0;
    p.valid = 1'b1;
    case (code)
      8'h02: ;
      8'h03: p.addr1_rd = 1'b1;
      8'h04: p.send_cmd = 1'b1;
      8'h05: begin p.addr1_rd = 1'b1; p.rd = XF_ONE; end
      8'h06: begin p.send_cmd = 1'b1; p.wr = XF_ONE; end
      8'h07: begin p.send_cmd = 1'b1; p.rstart = 1'b1; p.rd = XF_ONE; end
      8'h08: begin p.send_cmd = 1'b1; p.wr = XF_TWO; end
      8'h09: begin p.send_cmd = 1'b1; p.rstart = 1'b1; p.rd = XF_TWO; end
      8'h0A: begin p.send_cmd = 1'b1; p.wr = XF_BLOCK; end
      8'h0B: begin p.send_cmd = 1'b1; p.rstart = 1'b1; p.rd = XF_BLOCK; end
      8'h0C: begin p.send_cmd = 1'b1; p.wr = XF_TWO; p.rstart = 1'b1; p.rd = XF_TWO; end
      8'h0D: begin p.send_cmd = 1'b1; p.wr = XF_BLOCK; p.rstart = 1'b1; p.rd = XF_BLOCK; end
      default: p.valid = 1'b0;
    endcase
    return p;
  endfunction

  function automatic logic count_ok(input logic [7:0] n, input int max_n);
    return (n != 8'd0) && (int'(n) <= max_n);
  endfunction

  function automatic logic [7:0] addr_byte(input logic [7:0] a, input logic rd);
    return {a[7:1], rd};
  endfunction

  function automatic logic [7:0] fixed_len(input xfer_e k);
    case (k)
      XF_ONE:  return 8'd1;
      XF_TWO:  return 8'd2;
      default: return 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/smb_regfile.sv
module smb_regfile
  import smb_seq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NDATA  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              alarm_evt,
  input  logic [7:0]        alarm_addr_in,
  input  logic [15:0]       alarm_data_in,
  output logic              start,
  output logic [7:0]        start_code,
  output logic [7:0]        addr_q,
  output logic [7:0]        cmd_q,
  output logic [7:0]        bcnt_q,
  input  logic [$clog2(NDATA)-1:0] rd_idx,
  output logic [7:0]        rd_byte,
  input  logic              seq_fin,
  input  logic [4:0]        seq_res,
  input  logic              seq_dwe,
  input  logic [$clog2(NDATA)-1:0] seq_didx,
  input  logic [7:0]        seq_dval,
  input  logic              seq_bwe,
  input  logic [7:0]        seq_bval
);
  localparam int IW = $clog2(NDATA);
  localparam logic [ADDR_W-1:0] A_PROTO = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ADDR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_DATA0 = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_BCNT  = ADDR_W'(4 + NDATA);
  localparam logic [ADDR_W-1:0] A_ALA   = ADDR_W'(5 + NDATA);
  localparam logic [ADDR_W-1:0] A_ALD0  = ADDR_W'(6 + NDATA);
  localparam logic [ADDR_W-1:0] A_ALD1  = ADDR_W'(7 + NDATA);

  logic [7:0] proto_q;
  logic       done_q, alarm_q;
  logic [4:0] res_q;
  logic [7:0] al_addr_q;
  logic [15:0] al_data_q;
  logic [7:0] data_q [NDATA];

  // Named host events
  logic busy, wr_proto, wr_stat;
  assign busy       = (proto_q != 8'h00);
  assign wr_proto   = host_we && (host_addr == A_PROTO);
  assign wr_stat    = host_we && (host_addr == A_STAT);
  assign start      = wr_proto && !busy && (host_wdata != 8'h00);
  assign start_code = host_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      proto_q <= '0;
      done_q <= 1'b0;
      alarm_q <= 1'b0;
      res_q <= '0;
      addr_q <= '0;
      cmd_q <= '0;
      bcnt_q <= '0;
      al_addr_q <= '0;
      al_data_q <= '0;
    end else begin
      if (seq_fin) proto_q <= 8'h00;
      else if (start) proto_q <= host_wdata;

      if (seq_fin) begin
        done_q <= 1'b1;
        res_q <= seq_res;
      end else if (wr_stat) begin
        done_q <= 1'b0;
      end

      if (alarm_evt) begin
        alarm_q <= 1'b1;
        al_addr_q <= alarm_addr_in;
        al_data_q <= alarm_data_in;
      end else if (wr_stat) begin
        alarm_q <= 1'b0;
      end

      if (host_we && host_addr == A_ADDR) addr_q <= host_wdata;
      if (host_we && host_addr == A_CMD) cmd_q <= host_wdata;
      if (seq_bwe) bcnt_q <= seq_bval;
      else if (host_we && host_addr == A_BCNT) bcnt_q <= host_wdata;
    end
  end

  for (genvar g = 0; g < NDATA; g++) begin : g_data
    logic host_hit, seq_hit;
    assign host_hit = host_we && (host_addr == ADDR_W'(4 + g));
    assign seq_hit  = seq_dwe && (seq_didx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_q[g] <= '0;
      else if (seq_hit) data_q[g] <= seq_dval;
      else if (host_hit) data_q[g] <= host_wdata;
    end
  end

  assign rd_byte = data_q[rd_idx];

  always_comb begin
    host_rdata = 8'h00;
    if (host_addr == A_PROTO) host_rdata = proto_q;
    else if (host_addr == A_STAT) host_rdata = {done_q, alarm_q, 1'b0, res_q};
    else if (host_addr == A_ADDR) host_rdata = addr_q;
    else if (host_addr == A_CMD) host_rdata = cmd_q;
    else if (host_addr >= A_DATA0 && host_addr < A_BCNT)
      host_rdata = data_q[IW'(host_addr - A_DATA0)];
    else if (host_addr == A_BCNT) host_rdata = bcnt_q;
    else if (host_addr == A_ALA) host_rdata = al_addr_q;
    else if (host_addr == A_ALD0) host_rdata = al_data_q[7:0];
    else if (host_addr == A_ALD1) host_rdata = al_data_q[15:8];
  end

  assert_fin_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fin |=> (proto_q == 8'h00) && done_q);

  assert_busy_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_proto && !seq_fin) |=> $stable(proto_q));

  assert_stat_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !seq_fin && !alarm_evt) |=> (!done_q && !alarm_q));

  assert_alarm_set_R13: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> alarm_q && (al_addr_q == $past(alarm_addr_in)));

endmodule

// File: rtl/smb_seq_fsm.sv
module smb_seq_fsm
  import smb_seq_pkg::*;
#(
  parameter int NDATA = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] start_code,
  input  logic [7:0] addr_q,
  input  logic [7:0] cmd_q,
  input  logic [7:0] bcnt_q,
  output logic [$clog2(NDATA)-1:0] rd_idx,
  input  logic [7:0] rd_byte,
  output logic       seq_fin,
  output logic [4:0] seq_res,
  output logic       seq_dwe,
  output logic [$clog2(NDATA)-1:0] seq_didx,
  output logic [7:0] seq_dval,
  output logic       seq_bwe,
  output logic [7:0] seq_bval,
  output logic       eng_req,
  output logic [2:0] eng_cmd,
  output logic [7:0] eng_wdata,
  input  logic       eng_ack,
  input  logic [7:0] eng_rdata,
  input  logic       eng_got_ack
);
  localparam int IW = $clog2(NDATA);

  seq_st_e    state;
  plan_t      plan_q, start_plan;
  logic [7:0] wlen, rlen, idx;
  logic [4:0] res_q;
  eng_cmd_e   cmd_c;

  assign start_plan = decode_proto(start_code);

  // Named internal events
  logic step_done, wr_nack, reject, w_last, r_last;
  seq_st_e after_w;
  assign step_done = eng_req && eng_ack;
  assign wr_nack   = step_done && (cmd_c == ENG_WRITE) && !eng_got_ack;
  assign reject    = !start_plan.valid ||
                     (start_plan.wr == XF_BLOCK && !count_ok(bcnt_q, NDATA));
  assign w_last    = (idx == wlen - 8'd1);
  assign r_last    = (idx == rlen - 8'd1);
  assign after_w   = plan_q.rstart ? S_START2 : S_STOP;

  always_comb begin
    eng_req = 1'b1;
    cmd_c = ENG_WRITE;
    eng_wdata = 8'h00;
    case (state)
      S_START1, S_START2: cmd_c = ENG_START;
      S_ADDR1: eng_wdata = addr_byte(addr_q, plan_q.addr1_rd);
      S_ADDR2: eng_wdata = addr_byte(addr_q, 1'b1);
      S_CMD:   eng_wdata = cmd_q;
      S_WCNT:  eng_wdata = wlen;
      S_WDATA: eng_wdata = rd_byte;
      S_RCNT:  cmd_c = ENG_RD_ACK;
      S_RDATA: cmd_c = r_last ? ENG_RD_NACK : ENG_RD_ACK;
      S_STOP:  cmd_c = ENG_STOP;
      default: begin eng_req = 1'b0; cmd_c = ENG_START; end
    endcase
  end
  assign eng_cmd = cmd_c;

  assign rd_idx   = idx[IW-1:0];
  assign seq_didx = idx[IW-1:0];
  assign seq_dval = eng_rdata;
  assign seq_dwe  = step_done && (state == S_RDATA);
  assign seq_bval = eng_rdata;
  assign seq_bwe  = step_done && (state == S_RCNT) && count_ok(eng_rdata, NDATA);
  assign seq_fin  = (state == S_FIN);
  assign seq_res  = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      plan_q <= '0;
      wlen <= '0;
      rlen <= '0;
      idx <= '0;
      res_q <= RES_OK;
    end else if (state == S_IDLE) begin
      if (start) begin
        idx <= '0;
        if (reject) begin
          res_q <= RES_UNSUP;
          state <= S_FIN;
        end else begin
          res_q <= RES_OK;
          plan_q <= start_plan;
          wlen <= (start_plan.wr == XF_BLOCK) ? bcnt_q : fixed_len(start_plan.wr);
          rlen <= fixed_len(start_plan.rd);
          state <= S_START1;
        end
      end
    end else if (state == S_FIN) begin
      state <= S_IDLE;
    end else if (step_done) begin
      if (wr_nack) begin
        res_q <= (state == S_ADDR1 || state == S_ADDR2) ? RES_ADDR_NAK : RES_DEV_ERR;
        state <= S_STOP;
      end else begin
        case (state)
          S_START1: state <= S_ADDR1;
          S_ADDR1: begin
            if (plan_q.addr1_rd) state <= (plan_q.rd != XF_NONE) ? S_RDATA : S_STOP;
            else state <= plan_q.send_cmd ? S_CMD : S_STOP;
          end
          S_CMD: begin
            if (plan_q.wr == XF_BLOCK) state <= S_WCNT;
            else if (plan_q.wr != XF_NONE) state <= S_WDATA;
            else state <= after_w;
          end
          S_WCNT: state <= S_WDATA;
          S_WDATA: begin
            if (w_last) begin
              idx <= '0;
              state <= after_w;
            end else begin
              idx <= idx + 8'd1;
            end
          end
          S_START2: state <= S_ADDR2;
          S_ADDR2: state <= (plan_q.rd == XF_BLOCK) ? S_RCNT : S_RDATA;
          S_RCNT: begin
            if (count_ok(eng_rdata, NDATA)) begin
              rlen <= eng_rdata;
              state <= S_RDATA;
            end else begin
              res_q <= RES_DEV_ERR;
              state <= S_STOP;
            end
          end
          S_RDATA: begin
            if (r_last) state <= S_STOP;
            else idx <= idx + 8'd1;
          end
          S_STOP: state <= S_FIN;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assert_cmd_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_ack) |=> eng_req && $stable(eng_cmd) && $stable(eng_wdata));

  assert_reject_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start && reject) |=> (!eng_req && seq_fin && seq_res == RES_UNSUP));

  assert_addr_nack_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_nack && (state == S_ADDR1 || state == S_ADDR2)) |=> (eng_req && eng_cmd == ENG_STOP));

  assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WDATA || state == S_RDATA) |-> (int'(idx) < NDATA));

  assert_fin_after_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && cmd_c == ENG_STOP) |=> (seq_fin && !eng_req));

endmodule

// File: rtl/smb_host_seq.sv
module smb_host_seq
  import smb_seq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NDATA  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              alarm_evt,
  input  logic [7:0]        alarm_addr_in,
  input  logic [15:0]       alarm_data_in,
  output logic              eng_req,
  output logic [2:0]        eng_cmd,
  output logic [7:0]        eng_wdata,
  input  logic              eng_ack,
  input  logic [7:0]        eng_rdata,
  input  logic              eng_got_ack
);
  localparam int IW = $clog2(NDATA);

  logic          start;
  logic [7:0]    start_code, addr_q, cmd_q, bcnt_q, rd_byte, seq_dval, seq_bval;
  logic [IW-1:0] rd_idx, seq_didx;
  logic          seq_fin, seq_dwe, seq_bwe;
  logic [4:0]    seq_res;

  smb_regfile #(.ADDR_W(ADDR_W), .NDATA(NDATA)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .alarm_evt(alarm_evt), .alarm_addr_in(alarm_addr_in), .alarm_data_in(alarm_data_in),
    .start(start), .start_code(start_code),
    .addr_q(addr_q), .cmd_q(cmd_q), .bcnt_q(bcnt_q),
    .rd_idx(rd_idx), .rd_byte(rd_byte),
    .seq_fin(seq_fin), .seq_res(seq_res),
    .seq_dwe(seq_dwe), .seq_didx(seq_didx), .seq_dval(seq_dval),
    .seq_bwe(seq_bwe), .seq_bval(seq_bval)
  );

  smb_seq_fsm #(.NDATA(NDATA)) fsm_i (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_code(start_code),
    .addr_q(addr_q), .cmd_q(cmd_q), .bcnt_q(bcnt_q),
    .rd_idx(rd_idx), .rd_byte(rd_byte),
    .seq_fin(seq_fin), .seq_res(seq_res),
    .seq_dwe(seq_dwe), .seq_didx(seq_didx), .seq_dval(seq_dval),
    .seq_bwe(seq_bwe), .seq_bval(seq_bval),
    .eng_req(eng_req), .eng_cmd(eng_cmd), .eng_wdata(eng_wdata),
    .eng_ack(eng_ack), .eng_rdata(eng_rdata), .eng_got_ack(eng_got_ack)
  );

endmodule

// File: tb/smb_host_seq_tb_top.sv
`timescale 1ns/1ps
module smb_host_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_we = 1'b0;
  logic [5:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic alarm_evt = 1'b0;
  logic [7:0] alarm_addr_in = '0;
  logic [15:0] alarm_data_in = '0;
  logic eng_req;
  logic [2:0] eng_cmd;
  logic [7:0] eng_wdata;
  logic eng_ack = 1'b0;
  logic [7:0] eng_rdata = '0;
  logic eng_got_ack = 1'b0;

  always #2.5 clk = ~clk;

  smb_host_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .alarm_evt(alarm_evt), .alarm_addr_in(alarm_addr_in), .alarm_data_in(alarm_data_in),
    .eng_req(eng_req), .eng_cmd(eng_cmd), .eng_wdata(eng_wdata),
    .eng_ack(eng_ack), .eng_rdata(eng_rdata), .eng_got_ack(eng_got_ack)
  );

  int checks = 0;
  int errors = 0;

  // command codes as required by R4
  localparam int C_ST = 0, C_WR = 1, C_RA = 2, C_RN = 3, C_SP = 4;

  int log_n = 0;
  int log_c [64];
  int log_d [64];
  int exp_n = 0;
  int exp_c [64];
  int exp_d [64];
  int nack_at = -1;
  logic [7:0] rd_src [64];
  int rd_ptr = 0;
  logic pend = 1'b0;
  logic [2:0] held_c;
  logic [7:0] held_d;

  // Byte engine model: accept, answer one cycle later, then idle a cycle.
  always @(posedge clk) begin
    eng_ack <= 1'b0;
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (pend) begin
      checks++;
      if (!eng_req || eng_cmd != held_c || (eng_cmd == 3'd1 && eng_wdata != held_d)) begin
        errors++;
        $display("FAIL R14: command changed before ack got %0d/0x%0h expected %0d/0x%0h",
                 eng_cmd, eng_wdata, held_c, held_d);
      end
      eng_ack <= 1'b1;
      pend <= 1'b0;
      eng_got_ack <= (log_n != nack_at);
      if (eng_cmd == 3'd2 || eng_cmd == 3'd3) begin
        eng_rdata <= rd_src[rd_ptr];
        rd_ptr++;
      end
      if (log_n < 64) begin
        log_c[log_n] = int'(eng_cmd);
        log_d[log_n] = (eng_cmd == 3'd1) ? int'(eng_wdata) : 0;
      end
      log_n++;
    end else if (eng_req && !eng_ack) begin
      pend <= 1'b1;
      held_c <= eng_cmd;
      held_d <= eng_wdata;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wreg(input logic [5:0] a, input logic [7:0] v);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rreg(input logic [5:0] a, output logic [7:0] v);
    @(negedge clk);
    host_addr = a;
    #1;
    v = host_rdata;
  endtask

  task automatic e_clr(); exp_n = 0; endtask
  task automatic e_put(input int c, input int d);
    exp_c[exp_n] = c; exp_d[exp_n] = d; exp_n++;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 400; i++) begin
      rreg(6'h00, v);
      if (v == 8'h00) break;
    end
  endtask

  task automatic run(input logic [7:0] code);
    log_n = 0; rd_ptr = 0;
    wreg(6'h00, code);
    wait_idle();
  endtask

  task automatic cmp_log(input string tag);
    chk({tag, " bus action count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk($sformatf("%s action %0d cmd", tag, i), log_c[i], exp_c[i]);
      chk($sformatf("%s action %0d byte", tag, i), log_d[i], exp_d[i]);
    end
  endtask

  task automatic chk_reg(input string tag, input logic [5:0] a, input int exp);
    logic [7:0] v;
    rreg(a, v);
    chk(tag, int'(v), exp);
  endtask

  task automatic t_reset();
    chk_reg("R1 protocol", 6'h00, 0);
    chk_reg("R1 status", 6'h01, 0);
    chk_reg("R1 count", 6'h24, 0);
    chk_reg("R1 data0", 6'h04, 0);
    chk("R1 eng_req", int'(eng_req), 0);
  endtask

  task automatic t_quick();
    wreg(6'h02, 8'hA4);
    run(8'h02);
    e_clr(); e_put(C_ST,0); e_put(C_WR,8'hA4); e_put(C_SP,0);
    cmp_log("R4 quick write");
    chk_reg("R3 protocol cleared", 6'h00, 0);
    chk_reg("R3 status ok", 6'h01, 8'h80);
    run(8'h03);
    e_clr(); e_put(C_ST,0); e_put(C_WR,8'hA5); e_put(C_SP,0);
    cmp_log("R4 quick read");
  endtask

  task automatic t_bytes();
    wreg(6'h03, 8'h33);
    run(8'h04);
    e_clr(); e_put(C_ST,0); e_put(C_WR,8'hA4); e_put(C_WR,8'h33); e_put(C_SP,0);
    cmp_log("R4 send byte");
    rd_src[0] = 8'h5C;
    run(8'h05);
    e_clr(); e_put(C_ST,0); e_put(C_WR,8'hA5); e_put(C_RN,0); e_put(C_SP,0);
    cmp_log("R4 receive byte");
    chk_reg("R4 receive byte data0", 6'h04, 8'h5C);
  endtask

  task automatic t_word();
    wreg(6'h03, 8'h10);
    rd_src[0] = 8'h9E;
    run(8'h07);
    e_clr(); e_put(C_ST,0); e_put(C_WR,8'hA4); e_put(C_WR,8'h10);
    e_put(C_ST,0); e_put(C_WR,8'hA5); e_put(C_RN,0); e_put(C_SP,0);
    cmp_log("R5 byte-data read");
    chk_reg("R5 byte-data read data0", 6'h04, 8'h9E);
    wreg(6'h04, 8'h34); wreg(6'h05, 8'h12);
    run(8'h08);
    e_clr(); e_put(C_ST,0); e_put(C_WR,8'hA4); e_put(C_WR,8'h10);
    e_put(C_WR,8'h34); e_put(C_WR,8'h12); e_put(C_SP,0);
    cmp_log("R5 word write little-endian");
    rd_src[0] = 8'hCD; rd_src[1] = 8'hAB;
    run(8'h09);
    e_clr(); e_put(C_ST,0); e_put(C_WR,8'hA4); e_put(C_WR,8'h10);
    e_put(C_ST,0); e_put(C_WR,8'hA5); e_put(C_RA,0); e_put(C_RN,0); e_put(C_SP,0);
    cmp_log("R5 word read");
    chk_reg("R5 word read low", 6'h04, 8'hCD);
    chk_reg("R5 word read high", 6'h05, 8'hAB);
  endtask

  task automatic t_proc();
    wreg(6'h04, 8'h01); wreg(6'h05, 8'h02);
    rd_src[0] = 8'h81; rd_src[1] = 8'h82;
    run(8'h0C);
    e_clr(); e_put(C_ST,0); e_put(C_WR,8'hA4); e_put(C_WR,8'h10);
    e_put(C_WR,8'h01); e_put(C_WR,8'h02); e_put(C_ST,0); e_put(C_WR,8'hA5);
    e_put(C_RA,0); e_put(C_RN,0); e_put(C_SP,0);
    cmp_log("R6 process call");
    chk_reg("R6 reply low", 6'h04, 8'h81);
    chk_reg("R6 reply high", 6'h05, 8'h82);
  endtask

  task automatic t_block_write();
    wreg(6'h24, 8'd3);
    wreg(6'h04, 8'h11); wreg(6'h05, 8'h22); wreg(6'h06, 8'h33);
    run(8'h0A);
    e_clr(); e_put(C_ST,0); e_put(C_WR,8'hA4); e_put(C_WR,8'h10); e_put(C_WR,3);
    e_put(C_WR,8'h11); e_put(C_WR,8'h22); e_put(C_WR,8'h33); e_put(C_SP,0);
    cmp_log("R7 block write");
    chk_reg("R7 block write status", 6'h01, 8'h80);
    wreg(6'h24, 8'd0);
    run(8'h0A);
    chk("R7 count 0 no bus activity", log_n, 0);
    chk_reg("R7 count 0 status", 6'h01, 8'h99);
    wreg(6'h24, 8'd33);
    run(8'h0A);
    chk("R7 count 33 no bus activity", log_n, 0);
    chk_reg("R7 count 33 status", 6'h01, 8'h99);
  endtask

  task automatic t_block_read();
    rd_src[0] = 8'd4; rd_src[1] = 8'hA0; rd_src[2] = 8'hA1;
    rd_src[3] = 8'hA2; rd_src[4] = 8'hA3;
    run(8'h0B);
    e_clr(); e_put(C_ST,0); e_put(C_WR,8'hA4); e_put(C_WR,8'h10);
    e_put(C_ST,0); e_put(C_WR,8'hA5); e_put(C_RA,0);
    e_put(C_RA,0); e_put(C_RA,0); e_put(C_RA,0); e_put(C_RN,0); e_put(C_SP,0);
    cmp_log("R8 block read");
    chk_reg("R8 received count", 6'h24, 4);
    for (int i = 0; i < 4; i++)
      chk_reg($sformatf("R8 payload %0d", i), 6'(4 + i), 8'hA0 + i);
    rd_src[0] = 8'd0;
    run(8'h0B);
    e_clr(); e_put(C_ST,0); e_put(C_WR,8'hA4); e_put(C_WR,8'h10);
    e_put(C_ST,0); e_put(C_WR,8'hA5); e_put(C_RA,0); e_put(C_SP,0);
    cmp_log("R8 bad received count");
    chk_reg("R8 bad count status", 6'h01, 8'h91);
  endtask

  task automatic t_bpc();
    wreg(6'h24, 8'd2);
    wreg(6'h04, 8'h55); wreg(6'h05, 8'h66);
    rd_src[0] = 8'd1; rd_src[1] = 8'h77;
    run(8'h0D);
    e_clr(); e_put(C_ST,0); e_put(C_WR,8'hA4); e_put(C_WR,8'h10); e_put(C_WR,2);
    e_put(C_WR,8'h55); e_put(C_WR,8'h66); e_put(C_ST,0); e_put(C_WR,8'hA5);
    e_put(C_RA,0); e_put(C_RN,0); e_put(C_SP,0);
    cmp_log("R9 block process call");
    chk_reg("R9 reply count", 6'h24, 1);
    chk_reg("R9 reply data0", 6'h04, 8'h77);
  endtask

  task automatic t_nack();
    nack_at = 1;
    run(8'h02);
    e_clr(); e_put(C_ST,0); e_put(C_WR,8'hA4); e_put(C_SP,0);
    cmp_log("R10 address nack");
    chk_reg("R10 address nack status", 6'h01, 8'h90);
    nack_at = 2;
    run(8'h08);
    e_clr(); e_put(C_ST,0); e_put(C_WR,8'hA4); e_put(C_WR,8'h10); e_put(C_SP,0);
    cmp_log("R10 command nack");
    chk_reg("R10 command nack status", 6'h01, 8'h91);
    nack_at = -1;
  endtask

  task automatic t_unsup();
    run(8'h82);
    chk("R11 error-check bit no bus activity", log_n, 0);
    chk_reg("R11 error-check bit status", 6'h01, 8'h99);
    run(8'h0E);
    chk("R11 unknown code no bus activity", log_n, 0);
    chk_reg("R11 unknown code status", 6'h01, 8'h99);
  endtask

  task automatic t_busy();
    logic [7:0] v;
    wreg(6'h04, 8'h34); wreg(6'h05, 8'h12);
    log_n = 0; rd_ptr = 0;
    wreg(6'h00, 8'h08);
    wreg(6'h00, 8'h02);
    rreg(6'h00, v);
    chk("R2 protocol holds code while busy", int'(v), 8'h08);
    wait_idle();
    e_clr(); e_put(C_ST,0); e_put(C_WR,8'hA4); e_put(C_WR,8'h10);
    e_put(C_WR,8'h34); e_put(C_WR,8'h12); e_put(C_SP,0);
    cmp_log("R2 busy write ignored");
  endtask

  task automatic t_status_alarm();
    run(8'h02);
    chk_reg("R12 done before clear", 6'h01, 8'h80);
    wreg(6'h01, 8'hFF);
    chk_reg("R12 done cleared", 6'h01, 8'h00);
    @(negedge clk);
    alarm_evt = 1'b1; alarm_addr_in = 8'h5A; alarm_data_in = 16'hBEEF;
    @(negedge clk);
    alarm_evt = 1'b0;
    chk_reg("R13 alarm flag", 6'h01, 8'h40);
    chk_reg("R13 alarm address", 6'h25, 8'h5A);
    chk_reg("R13 alarm data low", 6'h26, 8'hEF);
    chk_reg("R13 alarm data high", 6'h27, 8'hBE);
    wreg(6'h01, 8'h00);
    chk_reg("R12 alarm cleared", 6'h01, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) rd_src[i] = 8'h00;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_quick();
    t_bytes();
    t_word();
    t_proc();
    t_block_write();
    t_block_read();
    t_bpc();
    t_nack();
    t_unsup();
    t_busy();
    t_status_alarm();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule